// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This unit sits beside the execute stage of a 16-bit processor. It resolves the eight conditional test instructions and tells the fetch logic when to drop the following instruction. Each cycle may present one instruction: a valid strobe, the 5-bit opcode and the two operand values, b and a. The operands are already resolved, so either one may have come from an inline literal. The unit drives `cond_true_o` when a conditional instruction passes. It drives `skip_o` during each cycle whose presented instruction must be discarded.

A failed test arms a pending skip. The next valid instruction is then discarded. If the discarded instruction is itself a conditional, it is not evaluated and the skip stays armed. As a result, a whole run of conditionals is dropped together with the first ordinary instruction that follows it. Cycles with the strobe low do not advance this state.

Top module: `cond_skip_unit`

## Requirements
- R1: Opcode 0x10 passes when (b & a) is nonzero.
- R2: Opcode 0x11 passes when (b & a) is zero.
- R3: Opcode 0x12 passes when b equals a, and opcode 0x13 passes when b differs from a.
- R4: Opcode 0x14 passes when b > a and opcode 0x16 passes when b < a, both compared as unsigned numbers.
- R5: Opcode 0x17 passes when b < a and opcode 0x15 passes when b > a, both compared as two's-complement signed numbers.
- R6: `cond_true_o` is high only while `valid_i` is high, the opcode lies in 0x10..0x17, no skip is pending and the test passes; in every other case it is low, in the same cycle.
- R7: When a conditional that is not being skipped fails, the next valid instruction sees `skip_o` high for exactly that one cycle.
- R8: While a skip is pending, a valid conditional (0x10..0x17) is discarded without evaluation and keeps the skip pending. The first valid instruction outside that range is discarded and clears the skip.
- R9: A cycle with `valid_i` low drives `skip_o` low and leaves the pending state unchanged.
- R10: Asserting `rst_ni` low clears any pending skip, so the first valid instruction after reset is not discarded.
- R11: When no skip is pending, a passing conditional or an instruction outside 0x10..0x17 leaves the next instruction not discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 5 | Basic opcode of the presented instruction |
| opb_i | input | DATA_W | Resolved operand b |
| opa_i | input | DATA_W | Resolved operand a |
| cond_true_o | output | 1 | Conditional evaluated and passed |
| skip_o | output | 1 | Presented instruction is to be discarded |

## Verification
The bench builds the unit with `DATA_W` = 4. At that width, every b and a pair can be applied for each of the eight conditional opcodes. This covers every sign combination, equal operands, and the extremes of both orderings. Each pass/fail result is then confirmed by the skip it should or should not cause on the following instruction. The chaining of skips through runs of conditionals, idle gaps and a reset in the middle of a run is driven as directed sequences.

// File: rtl/cond_skip_pkg.sv
package cond_skip_pkg;

  typedef enum logic [2:0] {
    TST_BIT_ANY  = 3'd0,
    TST_BIT_NONE = 3'd1,
    TST_EQ       = 3'd2,
    TST_NE       = 3'd3,
    TST_UGT      = 3'd4,
    TST_SGT      = 3'd5,
    TST_ULT      = 3'd6,
    TST_SLT      = 3'd7
  } test_sel_e;

  localparam int unsigned OPC_W = 5;

  // conditional tests occupy 0x10..0x17
  function automatic logic is_cond_op(input logic [OPC_W-1:0] op);
    return op[4:3] == 2'b10;
  endfunction

  typedef struct packed {
    logic any_set;
    logic eq;
    logic ult;
    logic slt;
  } cmp_flags_t;

endpackage

// File: rtl/cond_cmp.sv
module cond_cmp
  import cond_skip_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter bit          USE_SUB  = 1'b1
) (
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] opa_i,
  output cmp_flags_t        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic ult;

  generate
    if (USE_SUB) begin : g_sub
      logic [DATA_W:0] diff;
      assign diff = {1'b0, opb_i} - {1'b0, opa_i};
      assign ult  = diff[DATA_W];
    end else begin : g_cmp
      assign ult = opb_i < opa_i;
    end
  endgenerate

  always_comb begin
    flags_o.any_set = |(opb_i & opa_i);
    flags_o.eq      = opb_i == opa_i;
    flags_o.ult     = ult;
    // sign bits differ: b is smaller exactly when b is negative
    flags_o.slt     = (opb_i[MSB] ^ opa_i[MSB]) ? opb_i[MSB] : ult;
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_skip_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  cmp_flags_t       flags_i,
  output logic             is_cond_o,
  output logic             pass_o
);
  test_sel_e sel;

  assign sel       = test_sel_e'(opcode_i[2:0]);
  assign is_cond_o = is_cond_op(opcode_i);

  always_comb begin
    unique case (sel)
      TST_BIT_ANY:  pass_o =  flags_i.any_set;
      TST_BIT_NONE: pass_o = ~flags_i.any_set;
      TST_EQ:       pass_o =  flags_i.eq;
      TST_NE:       pass_o = ~flags_i.eq;
      TST_UGT:      pass_o = ~flags_i.ult & ~flags_i.eq;
      TST_SGT:      pass_o = ~flags_i.slt & ~flags_i.eq;
      TST_ULT:      pass_o =  flags_i.ult;
      TST_SLT:      pass_o =  flags_i.slt;
      default:      pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/skip_track.sv
module skip_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic is_cond_i,
  input  logic pass_i,
  output logic cond_true_o,
  output logic skip_o,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (valid_i) begin
      // a skipped conditional extends the chain without being evaluated
      if (pend_q) pend_d = is_cond_i;
      else        pend_d = is_cond_i & ~pass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign skip_o      = valid_i & pend_q;
  assign cond_true_o = valid_i & ~pend_q & is_cond_i & pass_i;
  assign pend_o      = pend_q;

endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit
  import cond_skip_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter bit          USE_SUB = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        opcode_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] opa_i,
  output logic              cond_true_o,
  output logic              skip_o
);
  cmp_flags_t flags;
  logic       is_cond;
  logic       pass;
  logic       pend_q;

  cond_cmp #(
    .DATA_W  (DATA_W),
    .USE_SUB (USE_SUB)
  ) u_cmp (
    .opb_i   (opb_i),
    .opa_i   (opa_i),
    .flags_o (flags)
  );

  cond_eval u_eval (
    .opcode_i  (opcode_i),
    .flags_i   (flags),
    .is_cond_o (is_cond),
    .pass_o    (pass)
  );

  skip_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .is_cond_i   (is_cond),
    .pass_i      (pass),
    .cond_true_o (cond_true_o),
    .skip_o      (skip_o),
    .pend_o      (pend_q)
  );

endmodule

// File: rtl/cond_skip_unit_chk.sv
module cond_skip_unit_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [4:0]        opcode_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] opa_i,
  input logic              cond_true_o,
  input logic              skip_o,
  input logic              pend_q
);
  logic in_range;
  assign in_range = opcode_i[4:3] == 2'b10;

  AST_TRUE_NEEDS_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_true_o |-> (valid_i && in_range)); // R6

  AST_TRUE_SKIP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cond_true_o && skip_o)); // R6

  AST_EQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_true_o && opcode_i == 5'h12) |-> (opb_i == opa_i)); // R3

  AST_FAIL_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !skip_o && in_range && !cond_true_o) |=> pend_q); // R7

  AST_CHAIN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && in_range) |=> pend_q); // R8

  AST_CHAIN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && !in_range) |=> !pend_q); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pend_q)); // R9

  AST_SKIP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> valid_i); // R9

  AST_PASS_NO_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !skip_o && (cond_true_o || !in_range)) |=> !pend_q); // R11

endmodule

bind cond_skip_unit cond_skip_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .opcode_i    (opcode_i),
  .opb_i       (opb_i),
  .opa_i       (opa_i),
  .cond_true_o (cond_true_o),
  .skip_o      (skip_o),
  .pend_q      (pend_q)
);

// File: tb/cond_skip_unit_tb_top.sv
`timescale 1ns/1ps
module cond_skip_unit_tb_top;
  localparam int unsigned DW = 4;
  localparam int unsigned NV = 1 << DW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid = 1'b0;
  logic [4:0]    opc = '0;
  logic [DW-1:0] b = '0;
  logic [DW-1:0] a = '0;
  logic          cond_true, skip;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cond_skip_unit #(.DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid),
    .opcode_i    (opc),
    .opb_i       (b),
    .opa_i       (a),
    .cond_true_o (cond_true),
    .skip_o      (skip)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic bit model_pass(input int op, input int bv, input int av);
    int sb, sa;
    sb = (bv >= NV/2) ? bv - NV : bv;
    sa = (av >= NV/2) ? av - NV : av;
    case (op & 7)
      0: return (bv & av) != 0;
      1: return (bv & av) == 0;
      2: return bv == av;
      3: return bv != av;
      4: return bv > av;
      5: return sb > sa;
      6: return bv < av;
      default: return sb < sa;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op & 7)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 6: return "R4";
      default: return "R5";
    endcase
  endfunction

  // drive after negedge, sample mid low phase, then let the edge pass
  task automatic drive(input logic v, input int op, input int bv, input int av);
    @(negedge clk);
    valid = v;
    opc   = 5'(op);
    b     = DW'(bv);
    a     = DW'(av);
    #1;
  endtask

  initial begin
    #20000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(1'b1, 5'h01, 0, 0);
    chk("R10", "skip in reset", skip, 1'b0);
    chk("R10", "cond_true in reset", cond_true, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    // exhaustive: every conditional, every operand pair, then a follower
    for (int op = 16; op < 24; op++) begin
      for (int bv = 0; bv < NV; bv++) begin
        for (int av = 0; av < NV; av++) begin
          bit p;
          p = model_pass(op, bv, av);
          drive(1'b1, op, bv, av);
          chk(req_of(op), "cond_true", cond_true, p);
          chk("R6", "no skip on evaluated cond", skip, 1'b0);
          drive(1'b1, 5'h02, bv, av);
          if (p) chk("R11", "follower after pass", skip, 1'b0);
          else   chk("R7", "follower after fail", skip, 1'b1);
          chk("R6", "cond_true on plain op", cond_true, 1'b0);
        end
      end
    end

    // non-conditional opcodes never flag nor arm
    for (int op = 0; op < 32; op++) begin
      if (op >= 16 && op < 24) continue;
      drive(1'b1, op, 0, 0);
      chk("R6", "cond_true outside range", cond_true, 1'b0);
      drive(1'b1, 5'h01, 0, 0);
      chk("R11", "no skip after plain op", skip, 1'b0);
    end

    // strobe low: no flag even for a passing test
    drive(1'b0, 5'h12, 3, 3);
    chk("R6", "cond_true with valid low", cond_true, 1'b0);

    // chain: fail, two skipped conds (one would pass), idle gap, plain op ends chain
    drive(1'b1, 5'h12, 1, 2);
    chk("R3", "IFE fails", cond_true, 1'b0);
    drive(1'b1, 5'h12, 5, 5);
    chk("R8", "skipped cond discarded", skip, 1'b1);
    chk("R8", "skipped cond not evaluated", cond_true, 1'b0);
    drive(1'b0, 5'h01, 0, 0);
    chk("R9", "skip low while idle", skip, 1'b0);
    drive(1'b1, 5'h10, 15, 15);
    chk("R8", "second skipped cond", skip, 1'b1);
    drive(1'b0, 5'h01, 0, 0);
    drive(1'b0, 5'h01, 0, 0);
    drive(1'b1, 5'h01, 0, 0);
    chk("R9", "pending held over idle", skip, 1'b1);
    drive(1'b1, 5'h01, 0, 0);
    chk("R8", "chain cleared by plain op", skip, 1'b0);

    // skip lasts one instruction only
    drive(1'b1, 5'h16, 9, 2);
    drive(1'b1, 5'h03, 0, 0);
    chk("R7", "single skip", skip, 1'b1);
    drive(1'b1, 5'h03, 0, 0);
    chk("R7", "skip one cycle only", skip, 1'b0);

    // reset while pending
    drive(1'b1, 5'h13, 4, 4);
    @(negedge clk);
    valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b1, 5'h01, 0, 0);
    chk("R10", "pending cleared by reset", skip, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule